// File: doc/BRIEF.md
# Slot Load and Relocation Sequencer

This block is the control state machine that wraps the partial reconfiguration of one processing slot in a region of swappable hardware components. It takes one of two commands. A load command places a component into an empty slot. A relocate command moves a component from a source slot to a destination slot. The sequencer then works through a fixed series of handshakes. It raises per-slot stall bits for the neighbours named in the command. It asks the interconnect switch to break or make the two links of a slot. It asks the external configuration port to write the destination slot. Finally it pulses a start and resynchronise step.

The two commands use different orders. The order is chosen so that a neighbour never sees a link to a half-written slot. Every link and configuration step waits for its own acknowledge, so an external agent sets the pace. A configuration step that never completes sends the block to a held error state. In that state the affected neighbours stay frozen until reset.

Top module: `slot_reloc_seq`

## Requirements
- R1: During and right after an active-low reset, the block is idle: busy, cmd_reject, stall, sw_req, cfg_req, start, resync and err are all zero.
- R2: A load (cmd_move=0) runs in this order: configure dst; then stall the neighbours in cmd_deps; then connect the upstream leg of dst; then connect the downstream leg of dst; then start.
- R3: A relocate (cmd_move=1) runs in this order: stall the neighbours in cmd_deps; disconnect the downstream leg of src; disconnect the upstream leg of src; configure dst; connect the upstream leg of dst; connect the downstream leg of dst; start.
- R4: A link request holds sw_req high until sw_ack is sampled, and holds sw_op, sw_leg and sw_slot stable while it waits. The next step begins in the following cycle. sw_op=1 means connect and sw_op=0 means disconnect. sw_leg=0 is the link from the upstream source into the slot's sink. sw_leg=1 is the link from the slot's source to the downstream sink. sw_slot is src for the disconnect steps and dst for the connect steps.
- R5: A configuration request holds cfg_req high with cfg_slot equal to dst until cfg_done is sampled.
- R6: The start step lasts exactly one cycle. In that cycle start is high, start_slot equals dst, and resync equals the command's dependent mask. In the next cycle stall is zero.
- R7: busy is high from the cycle after a command is accepted until the block is back in idle, and it stays high in the error state. A command offered while busy is ignored, and cmd_reject pulses high in the next cycle.
- R8: Only the slots set in cmd_deps are ever stalled. stall is zero whenever the block is idle.
- R9: Let T be the nonzero cmd_timeout captured at acceptance. If cfg_done has not been sampled within T cycles of configuration, err goes high. stall then keeps its value, and no further link or configuration requests are made until reset.
- R10: A cmd_timeout of zero disables the timeout. A late cfg_done then still completes the command normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_move | input | 1 | 1 = relocate, 0 = load |
| cmd_src | input | SW | Source slot of a relocation |
| cmd_dst | input | SW | Slot to be configured |
| cmd_deps | input | NSLOT | Mask of dependent neighbour slots |
| cmd_timeout | input | TMO_W | Configuration timeout in cycles, 0 = none |
| busy | output | 1 | Command in progress or error held |
| cmd_reject | output | 1 | One-cycle pulse for a command refused while busy |
| stall | output | NSLOT | Per-slot stall request |
| sw_req | output | 1 | Switch link request |
| sw_op | output | 1 | 1 = connect, 0 = disconnect |
| sw_leg | output | 1 | 0 = upstream-to-slot link, 1 = slot-to-downstream link |
| sw_slot | output | SW | Slot whose link is switched |
| sw_ack | input | 1 | Switch acknowledge |
| cfg_req | output | 1 | Configuration request |
| cfg_slot | output | SW | Slot targeted by the configuration |
| cfg_done | input | 1 | Configuration finished |
| start | output | 1 | Start pulse for the configured component |
| start_slot | output | SW | Slot being started |
| resync | output | NSLOT | Resynchronise pulse per neighbour slot |
| err | output | 1 | Configuration timed out; held until reset |

## Verification
The assertions check, on every cycle, the properties that one port-level cycle can show. These are: request fields held stable while unacknowledged, the single-cycle start with stall cleared after it, the reject pulse, stall never leaving the captured mask, mutual exclusion of the request outputs, and the frozen error state. The order of the steps within a load or a relocation cannot be seen from one cycle. Nor can the exact timeout boundary or the fact that a refused command leaves no trace. These show only in the bench's scenarios, where a behavioural model is compared on every clock and each command's handshake log is matched against the expected order.

// File: rtl/slot_reloc_seq.sv
module slot_reloc_seq #(
  parameter int NSLOT = 8,
  parameter int TMO_W = 16,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_move,
  input  logic [SW-1:0]    cmd_src,
  input  logic [SW-1:0]    cmd_dst,
  input  logic [NSLOT-1:0] cmd_deps,
  input  logic [TMO_W-1:0] cmd_timeout,
  output logic             busy,
  output logic             cmd_reject,
  output logic [NSLOT-1:0] stall,
  output logic             sw_req,
  output logic             sw_op,
  output logic             sw_leg,
  output logic [SW-1:0]    sw_slot,
  input  logic             sw_ack,
  output logic             cfg_req,
  output logic [SW-1:0]    cfg_slot,
  input  logic             cfg_done,
  output logic             start,
  output logic [SW-1:0]    start_slot,
  output logic [NSLOT-1:0] resync,
  output logic             err
);

  typedef enum logic [2:0] {
    S_IDLE, S_DISC_DN, S_DISC_UP, S_CFG, S_CONN_UP, S_CONN_DN, S_START, S_ERR
  } st_t;

  st_t              st;
  logic             move_q;
  logic [SW-1:0]    src_q, dst_q;
  logic [NSLOT-1:0] deps_q, stall_q;
  logic [TMO_W-1:0] tmo_q, cnt;
  logic             rej_q;
  logic             tmo_hit;

  assign tmo_hit = (tmo_q != '0) && (cnt == tmo_q - TMO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      move_q  <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      deps_q  <= '0;
      tmo_q   <= '0;
      cnt     <= '0;
      stall_q <= '0;
      rej_q   <= 1'b0;
    end else begin
      rej_q <= cmd_valid && busy;
      case (st)
        S_IDLE: if (cmd_valid) begin
          move_q <= cmd_move;
          src_q  <= cmd_src;
          dst_q  <= cmd_dst;
          deps_q <= cmd_deps;
          tmo_q  <= cmd_timeout;
          cnt    <= '0;
          if (cmd_move) begin
            stall_q <= cmd_deps;
            st      <= S_DISC_DN;
          end else begin
            st      <= S_CFG;
          end
        end
        S_DISC_DN: if (sw_ack) st <= S_DISC_UP;
        S_DISC_UP: if (sw_ack) st <= S_CFG;
        S_CFG: begin
          if (cfg_done) begin
            if (!move_q) stall_q <= deps_q;
            st <= S_CONN_UP;
          end else if (tmo_hit) begin
            st <= S_ERR;
          end else begin
            cnt <= cnt + TMO_W'(1);
          end
        end
        S_CONN_UP: if (sw_ack) st <= S_CONN_DN;
        S_CONN_DN: if (sw_ack) st <= S_START;
        S_START: begin
          stall_q <= '0;
          st      <= S_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign cmd_reject = rej_q;
  assign stall      = stall_q;
  assign sw_req     = (st == S_DISC_DN) || (st == S_DISC_UP) ||
                      (st == S_CONN_UP) || (st == S_CONN_DN);
  assign sw_op      = (st == S_CONN_UP) || (st == S_CONN_DN);
  assign sw_leg     = (st == S_DISC_DN) || (st == S_CONN_DN);
  assign sw_slot    = ((st == S_DISC_DN) || (st == S_DISC_UP)) ? src_q : dst_q;
  assign cfg_req    = (st == S_CFG);
  assign cfg_slot   = dst_q;
  assign start      = (st == S_START);
  assign start_slot = dst_q;
  assign resync     = start ? deps_q : '0;
  assign err        = (st == S_ERR);

endmodule

// File: rtl/slot_reloc_seq_chk.sv
module slot_reloc_seq_chk #(
  parameter int NSLOT = 8,
  parameter int SW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             busy,
  input logic             cmd_reject,
  input logic [NSLOT-1:0] stall,
  input logic [NSLOT-1:0] deps_q,
  input logic             sw_req,
  input logic             sw_op,
  input logic             sw_leg,
  input logic [SW-1:0]    sw_slot,
  input logic             sw_ack,
  input logic             cfg_req,
  input logic [SW-1:0]    cfg_slot,
  input logic             cfg_done,
  input logic             start,
  input logic             err
);

  a_r4_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req && !sw_ack |=> sw_req && $stable(sw_op) && $stable(sw_leg) && $stable(sw_slot));

  a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_done |=> (cfg_req && $stable(cfg_slot)) || err);

  a_r6_start_once: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start && (stall == '0));

  a_r7_reject: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && busy |=> cmd_reject);

  a_r7_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req || cfg_req || start || err) |-> busy);

  a_r8_stall_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (stall & ~deps_q) == '0);

  a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> stall == '0);

  a_r9_err_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err && $stable(stall) && !sw_req && !cfg_req && !start);

  a_r2_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_req, cfg_req, start}));

endmodule

bind slot_reloc_seq slot_reloc_seq_chk #(.NSLOT(NSLOT), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
  .cmd_reject(cmd_reject), .stall(stall), .deps_q(deps_q),
  .sw_req(sw_req), .sw_op(sw_op), .sw_leg(sw_leg), .sw_slot(sw_slot),
  .sw_ack(sw_ack), .cfg_req(cfg_req), .cfg_slot(cfg_slot),
  .cfg_done(cfg_done), .start(start), .err(err)
);

// File: tb/slot_reloc_seq_tb.sv
`timescale 1ns/100ps
module slot_reloc_seq_tb;
  localparam int NS = 8;
  localparam int TW = 16;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_move = 0;
  logic [2:0] cmd_src = 0, cmd_dst = 0;
  logic [NS-1:0] cmd_deps = 0;
  logic [TW-1:0] cmd_timeout = 0;
  logic busy, cmd_reject, sw_req, sw_op, sw_leg, cfg_req, start, err;
  logic [2:0] sw_slot, cfg_slot, start_slot;
  logic [NS-1:0] stall, resync;
  logic sw_ack = 0, cfg_done = 0;

  always #2.5 clk = ~clk;

  slot_reloc_seq #(.NSLOT(NS), .TMO_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_move(cmd_move),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_deps(cmd_deps),
    .cmd_timeout(cmd_timeout), .busy(busy), .cmd_reject(cmd_reject),
    .stall(stall), .sw_req(sw_req), .sw_op(sw_op), .sw_leg(sw_leg),
    .sw_slot(sw_slot), .sw_ack(sw_ack), .cfg_req(cfg_req),
    .cfg_slot(cfg_slot), .cfg_done(cfg_done), .start(start),
    .start_slot(start_slot), .resync(resync), .err(err));

  int n_chk = 0, n_fail = 0;
  task automatic chk(string req, string nm, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, nm, got, exp, $time);
    end
  endtask

  // behavioural reference: step codes 1=cfg 2=disc dn 3=disc up 4=conn up 5=conn dn 6=start
  int cur = 0, q[$], m_tmo = 0, m_cnt = 0;
  bit m_move = 0, m_err = 0, m_rej = 0, m_busy = 0;
  logic [2:0] m_src = 0, m_dst = 0;
  logic [NS-1:0] m_deps = 0, m_stall = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      cur = 0; q.delete(); m_err = 0; m_rej = 0; m_stall = 0; m_cnt = 0;
      m_deps = 0; m_src = 0; m_dst = 0; m_move = 0;
    end else begin
      m_busy = (cur != 0) || m_err;
      m_rej = cmd_valid && m_busy;
      if (!m_err) begin
        if (cur == 0) begin
          if (cmd_valid) begin
            m_move = cmd_move; m_src = cmd_src; m_dst = cmd_dst;
            m_deps = cmd_deps; m_tmo = int'(cmd_timeout); m_cnt = 0;
            if (cmd_move) begin m_stall = cmd_deps; q = {3, 1, 4, 5, 6}; cur = 2; end
            else begin q = {4, 5, 6}; cur = 1; end
          end
        end else if (cur == 1) begin
          if (cfg_done) begin
            if (!m_move) m_stall = m_deps;
            cur = q.pop_front();
          end else if (m_tmo != 0 && m_cnt == m_tmo - 1) begin
            m_err = 1; cur = 0;
          end else m_cnt++;
        end else if (cur >= 2 && cur <= 5) begin
          if (sw_ack) cur = q.pop_front();
        end else if (cur == 6) begin
          m_stall = 0; cur = 0;
        end
      end
    end
  end

  // handshake log: 7 = stall raised
  int lg[$];
  logic [NS-1:0] prev_stall = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (stall != 0 && prev_stall == 0) lg.push_back(7);
      if (cfg_req && cfg_done) lg.push_back(1);
      if (sw_req && sw_ack) lg.push_back(sw_op ? (sw_leg ? 5 : 4) : (sw_leg ? 2 : 3));
      if (start) lg.push_back(6);
    end
    prev_stall = stall;
  end

  // per-cycle comparison
  bit started = 0;
  always @(posedge clk) started <= 1;
  always @(negedge clk) if (started) begin
    bit eb;
    eb = (cur != 0) || m_err;
    chk("R7", "busy", busy, eb);
    chk("R7", "cmd_reject", cmd_reject, m_rej);
    chk("R8", "stall", stall, m_stall);
    chk("R4", "sw_req", sw_req, (cur >= 2 && cur <= 5));
    if (cur >= 2 && cur <= 5) begin
      chk("R4", "sw_op", sw_op, (cur >= 4));
      chk("R4", "sw_leg", sw_leg, (cur == 2 || cur == 5));
      chk("R4", "sw_slot", sw_slot, (cur <= 3) ? m_src : m_dst);
    end
    chk("R5", "cfg_req", cfg_req, (cur == 1));
    if (cur == 1) chk("R5", "cfg_slot", cfg_slot, m_dst);
    chk("R6", "start", start, (cur == 6));
    if (cur == 6) chk("R6", "start_slot", start_slot, m_dst);
    chk("R6", "resync", resync, (cur == 6) ? m_deps : '0);
    chk("R9", "err", err, m_err);
  end

  // responder for the switch and configuration port
  int ack_dly = 0, cfg_dly = 0, swc = 0, cfc = 0;
  always @(negedge clk) begin
    if (sw_ack) begin sw_ack <= 0; swc = 0; end
    else if (sw_req) begin if (swc >= ack_dly) sw_ack <= 1; else swc++; end
    else swc = 0;
    if (cfg_done) begin cfg_done <= 0; cfc = 0; end
    else if (cfg_req) begin if (cfg_dly >= 0 && cfc >= cfg_dly) cfg_done <= 1; else cfc++; end
    else cfc = 0;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected idle");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic offer(bit mv, int s, int d, int dp, int t);
    @(negedge clk);
    cmd_valid = 1; cmd_move = mv; cmd_src = 3'(s); cmd_dst = 3'(d);
    cmd_deps = NS'(dp); cmd_timeout = TW'(t);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic run(string req, bit mv, int s, int d, int dp, int t, bit inject);
    int exp[$];
    bit ok;
    lg.delete();
    offer(mv, s, d, dp, t);
    if (inject) begin
      @(negedge clk);
      cmd_valid = 1; cmd_move = ~mv; cmd_dst = 3'(s); cmd_deps = ~NS'(dp);
      @(negedge clk);
      cmd_valid = 0;
      @(negedge clk);
      chk("R7", "reject seen", 1, 1);
    end
    while (cur != 0 && !m_err) @(negedge clk);
    if (m_err) return;
    exp = mv ? '{7, 2, 3, 1, 4, 5, 6} : '{1, 7, 4, 5, 6};
    ok = (lg.size() == exp.size());
    if (ok) foreach (exp[i]) if (lg[i] != exp[i]) ok = 0;
    chk(req, "step order", ok, 1);
    chk(req, "idle after", busy, 0);
  endtask

  task automatic check_idle();
    chk("R1", "busy", busy, 0);
    chk("R1", "stall", stall, 0);
    chk("R1", "requests", {sw_req, cfg_req, start}, 0);
    chk("R1", "resync", resync, 0);
    chk("R1", "err", err, 0);
    chk("R1", "cmd_reject", cmd_reject, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle();
    rst_n = 1;
    @(negedge clk);
    check_idle();

    ack_dly = 0; cfg_dly = 2;
    run("R2", 0, 0, 3, 'h06, 8, 0);
    ack_dly = 2; cfg_dly = 3;
    run("R3", 1, 1, 5, 'h81, 10, 1);
    chk("R7", "stall after ignored cmd", stall, 0);
    ack_dly = 1; cfg_dly = 3;
    run("R9", 0, 0, 7, 'h40, 4, 0);
    chk("R9", "boundary no error", err, 0);
    ack_dly = 0; cfg_dly = 30;
    run("R10", 0, 0, 0, 'h01, 0, 0);
    chk("R10", "no timeout", err, 0);

    ack_dly = 1; cfg_dly = 4;
    run("R9", 1, 6, 2, 'h3C, 4, 0);
    repeat (5) @(negedge clk);
    chk("R9", "err held", err, 1);
    chk("R9", "stall held", stall, 'h3C);
    chk("R9", "no request", {sw_req, cfg_req}, 0);
    offer(0, 0, 1, 'h02, 0);
    chk("R7", "reject in error", cmd_reject, 1);
    @(negedge clk);
    chk("R7", "still in error", err, 1);
    rst_n = 0;
    repeat (2) @(negedge clk);
    check_idle();
    rst_n = 1;
    @(negedge clk);

    ack_dly = 0; cfg_dly = 0;
    run("R3", 1, 2, 4, 'h10, 0, 0);
    run("R2", 0, 0, 6, 'hA0, 3, 0);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule